// File: doc/BRIEF.md
# Bit Scan Reverse Decode and Execute Unit

This unit takes an instruction byte window that has already been fetched and checks it for the bit-scan-reverse opcode. A match is the escape byte 0x0F, then 0xBD, then a ModRM byte, with an optional run of legacy prefixes in front and an optional REX byte. The source operand arrives on its own port, already read from a register or from memory. The unit finds the effective operand size and the destination register number. It returns the bit position of the highest set bit of the source within that size, a zero flag, and a fault for a locked encoding. The register write itself is left to a register file outside the unit, which receives a write enable and a register number.

Each strobe on `in_valid` produces one registered result one clock later. Address generation, segment and page checks and register storage are handled elsewhere. The unit ignores the ModRM r/m field, because the operand it selects has already been delivered.

Top module: `bsr_unit`

## Requirements
- R1: Byte k of `insn_bytes` sits at bits [8k+7:8k]. An instruction is recognised when, after the prefixes, the bytes are 0x0F, 0xBD and then ModRM. Any other sequence gives `not_bsr`=1 with `wr_en`, `ud_fault` and `zf` all at 0.
- R2: The legacy prefix scan accepts at most MAX_PFX bytes, each either 0x66 or 0xF0, in any mix. Operand size is encoded on `op_size` as 0=16 bits, 1=32 bits and 2=64 bits. A REX byte with W set gives 2, and this wins over 0x66. Otherwise 0x66 gives 0, and with neither the size is 1.
- R3: A byte in 0x40..0x4F is taken as REX only when `mode_64`=1 and the byte comes straight before 0x0F. Outside 64-bit mode such a byte, or a REX followed by a legacy prefix, leaves the instruction unrecognised.
- R4: `wr_reg` is {REX.R, ModRM[5:3]}, where REX.R is bit 2 of the REX byte. Without REX its top bit is 0.
- R5: A 0xF0 prefix on a recognised instruction gives `ud_fault`=1, `wr_en`=0 and `zf`=0.
- R6: When the source, truncated to the operand size, is non-zero, `wr_en`=1, `zf`=0 and `result` is the index of its highest 1 bit counted from bit 0. Source bits above the operand size have no effect.
- R7: When the truncated source is zero, `zf`=1 and `wr_en`=0, so the destination keeps its old value.
- R8: `other_flags` (the carry, overflow, sign, adjust and parity flags) is always 0.
- R9: `out_valid` rises exactly one clock after each `in_valid` cycle and is 0 otherwise. After reset every output is 0. The strobes `wr_en`, `ud_fault`, `zf` and `not_bsr` are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and source present this cycle |
| mode_64 | input | 1 | 1 = 64-bit mode, 0 = compatibility or legacy mode |
| insn_bytes | input | 8*(MAX_PFX+4) | Byte window, first byte in the lowest bits |
| src_data | input | 64 | Source operand value |
| out_valid | output | 1 | Result present |
| not_bsr | output | 1 | Window does not hold this instruction |
| ud_fault | output | 1 | Invalid-opcode fault (locked encoding) |
| wr_en | output | 1 | Write the destination register |
| wr_reg | output | 4 | Destination register number |
| op_size | output | 2 | Effective operand size code |
| result | output | 6 | Index of the highest set bit |
| zf | output | 1 | Zero flag |
| other_flags | output | 5 | Remaining arithmetic flags, fixed at 0 |

## Verification
Two cases are hard to reach from the ports. One is a source whose only set bits lie above the operand size, which has to be reported as zero. The other is a prefix run that fills the whole window in front of REX, or that runs past it. Directed vectors place set bits just above the 16-bit and 32-bit boundaries. They also stack four prefixes ahead of a REX byte and then five prefixes with no room left. A long randomised run then mixes 0x66, 0xF0, REX variants and a stray escape byte at every position, in both modes. This reaches REX-after-prefix orderings and lock combinations that the directed cases miss.

// File: rtl/bsr_pkg.sv
`timescale 1ns/1ps
package bsr_pkg;
   localparam int DW = 64;
   localparam int IW = $clog2(DW);

   localparam logic [7:0] BYTE_ESC  = 8'h0F;
   localparam logic [7:0] BYTE_BSR  = 8'hBD;
   localparam logic [7:0] BYTE_OSZ  = 8'h66;
   localparam logic [7:0] BYTE_LOCK = 8'hF0;
   localparam logic [3:0] REX_HI    = 4'h4;

   typedef enum logic [1:0] {
      OSZ_16 = 2'd0,
      OSZ_32 = 2'd1,
      OSZ_64 = 2'd2
   } osz_e;

   typedef struct packed {
      logic       hit;
      logic       lock;
      osz_e       osz;
      logic [3:0] dst;
   } dec_s;
endpackage

// File: rtl/bsr_decode.sv
`timescale 1ns/1ps
module bsr_decode
   import bsr_pkg::*;
#(
   parameter  int MAX_PFX = 4,
   localparam int NB      = MAX_PFX + 4,
   localparam int PW      = $clog2(NB) + 1
) (
   input  logic            mode_64,
   input  logic [NB*8-1:0] bytes_i,
   output dec_s            dec_o
);

   function automatic logic [7:0] pick(input logic [NB*8-1:0] v, input logic [PW-1:0] k);
      return v[{k, 3'b000} +: 8];
   endfunction

   logic [PW-1:0] pos, opc;
   logic          found, o16, lck, rex;
   logic [7:0]    cur, rexb, modrm;

   // legacy prefix run: stop at first byte that is neither 0x66 nor 0xF0
   always_comb begin
      pos   = PW'(MAX_PFX);
      found = 1'b0;
      o16   = 1'b0;
      lck   = 1'b0;
      cur   = 8'h00;
      for (int i = 0; i < MAX_PFX; i++) begin
         cur = bytes_i[8*i +: 8];
         if (!found) begin
            if (cur == BYTE_OSZ)       o16 = 1'b1;
            else if (cur == BYTE_LOCK) lck = 1'b1;
            else begin
               found = 1'b1;
               pos   = PW'(i);
            end
         end
      end
   end

   // optional REX, then escape, opcode, ModRM
   always_comb begin
      rexb  = pick(bytes_i, pos);
      rex   = mode_64 && (rexb[7:4] == REX_HI);
      opc   = pos + {{(PW-1){1'b0}}, rex};
      modrm = pick(bytes_i, opc + PW'(2));
      dec_o.hit  = (pick(bytes_i, opc) == BYTE_ESC) &&
                   (pick(bytes_i, opc + PW'(1)) == BYTE_BSR);
      dec_o.lock = lck;
      if (rex && rexb[3])  dec_o.osz = OSZ_64;
      else if (o16)        dec_o.osz = OSZ_16;
      else                 dec_o.osz = OSZ_32;
      dec_o.dst  = {rex & rexb[2], modrm[5:3]};
   end

endmodule

// File: rtl/bsr_lead_one.sv
`timescale 1ns/1ps
module bsr_lead_one #(
   parameter  int W    = 64,
   parameter  bit TREE = 1'b1,
   localparam int LW   = $clog2(W)
) (
   input  logic [W-1:0]  d,
   output logic [LW-1:0] idx,
   output logic          any
);

   if ((1 << LW) != W) begin : g_bad_w
      $error("bsr_lead_one: W must be a power of two");
   end

   assign any = |d;

   if (TREE) begin : g_tree
      // binary halving: log2(W) levels of wide OR and shift
      logic [W-1:0] v;
      always_comb begin
         v   = d;
         idx = '0;
         for (int k = LW - 1; k >= 0; k--) begin
            if ((v >> (1 << k)) != '0) begin
               idx[k] = 1'b1;
               v      = v >> (1 << k);
            end
         end
      end
   end else begin : g_linear
      // priority chain, last hit wins
      always_comb begin
         idx = '0;
         for (int i = 0; i < W; i++) begin
            if (d[i]) idx = LW'(i);
         end
      end
   end

endmodule

// File: rtl/bsr_unit.sv
`timescale 1ns/1ps
module bsr_unit
   import bsr_pkg::*;
#(
   parameter  int MAX_PFX   = 4,
   parameter  int SCAN_TREE = 1,
   localparam int NB        = MAX_PFX + 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            mode_64,
   input  logic [NB*8-1:0] insn_bytes,
   input  logic [63:0]     src_data,
   output logic            out_valid,
   output logic            not_bsr,
   output logic            ud_fault,
   output logic            wr_en,
   output logic [3:0]      wr_reg,
   output logic [1:0]      op_size,
   output logic [5:0]      result,
   output logic            zf,
   output logic [4:0]      other_flags
);

   if (MAX_PFX < 1 || MAX_PFX > 14) begin : g_bad_pfx
      $error("bsr_unit: MAX_PFX out of range");
   end
   if (SCAN_TREE != 0 && SCAN_TREE != 1) begin : g_bad_scan
      $error("bsr_unit: SCAN_TREE must be 0 or 1");
   end

   dec_s          dec;
   logic [DW-1:0] masked;
   logic [IW-1:0] idx;
   logic          any;

   bsr_decode #(.MAX_PFX(MAX_PFX)) u_dec (
      .mode_64 (mode_64),
      .bytes_i (insn_bytes),
      .dec_o   (dec)
   );

   always_comb begin
      unique case (dec.osz)
         OSZ_16:  masked = {{(DW-16){1'b0}}, src_data[15:0]};
         OSZ_32:  masked = {{(DW-32){1'b0}}, src_data[31:0]};
         default: masked = src_data;
      endcase
   end

   bsr_lead_one #(.W(DW), .TREE(SCAN_TREE != 0)) u_scan (
      .d   (masked),
      .idx (idx),
      .any (any)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         not_bsr   <= 1'b0;
         ud_fault  <= 1'b0;
         wr_en     <= 1'b0;
         zf        <= 1'b0;
         wr_reg    <= '0;
         op_size   <= '0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         not_bsr   <= in_valid && !dec.hit;
         ud_fault  <= in_valid && dec.hit && dec.lock;
         wr_en     <= in_valid && dec.hit && !dec.lock && any;
         zf        <= in_valid && dec.hit && !dec.lock && !any;
         if (in_valid) begin
            wr_reg  <= dec.dst;
            op_size <= dec.osz;
            result  <= idx;
         end
      end
   end

   assign other_flags = 5'b0;

endmodule

// File: rtl/bsr_unit_chk.sv
`timescale 1ns/1ps
module bsr_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       mode_64,
   input logic       out_valid,
   input logic       not_bsr,
   input logic       ud_fault,
   input logic       wr_en,
   input logic [3:0] wr_reg,
   input logic [1:0] op_size,
   input logic [5:0] result,
   input logic       zf
);

   a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r9_strobe_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || ud_fault || zf || not_bsr) |-> out_valid);
   a_r1_unrec_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      not_bsr |-> (!wr_en && !ud_fault && !zf));
   a_r5_lock_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
      ud_fault |-> (!wr_en && !zf));
   a_r7_zero_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
      zf |-> !wr_en);
   a_r6_idx_in_size: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((op_size == 2'd0 && result < 6'd16) ||
                 (op_size == 2'd1 && result < 6'd32) || op_size == 2'd2));
   a_r2_no_wide_legacy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode_64) |=> (op_size != 2'd2));
   a_r4_no_ext_legacy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode_64) |=> !wr_reg[3]);

endmodule

bind bsr_unit bsr_unit_chk u_chk (.*);

// File: tb/sim_bsr_unit.sv
`timescale 1ns/1ps
module sim_bsr_unit;
   localparam int NPF = 4;
   localparam int NBY = NPF + 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic            mode_64 = 1'b0;
   logic [NBY*8-1:0] insn_bytes = '0;
   logic [63:0]     src_data = '0;
   logic            out_valid, not_bsr, ud_fault, wr_en, zf;
   logic [3:0]      wr_reg;
   logic [1:0]      op_size;
   logic [5:0]      result;
   logic [4:0]      other_flags;

   always #10 clk = ~clk;

   bsr_unit #(.MAX_PFX(NPF)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_64(mode_64),
      .insn_bytes(insn_bytes), .src_data(src_data), .out_valid(out_valid),
      .not_bsr(not_bsr), .ud_fault(ud_fault), .wr_en(wr_en), .wr_reg(wr_reg),
      .op_size(op_size), .result(result), .zf(zf), .other_flags(other_flags)
   );

   int    vectors = 0;
   int    miscompares = 0;
   bit    finished = 0;
   string cur_tag = "reset";

   // expected values for the output of the previous edge
   bit   e_valid, e_hit, e_nb, e_ud, e_we, e_zf;
   int   e_size, e_reg, e_idx;
   bit   have_exp = 1;
   string e_tag = "reset";

   function automatic logic [63:0] pk(input int b0, b1, b2, b3, b4, b5, b6, b7);
      return {b7[7:0], b6[7:0], b5[7:0], b4[7:0], b3[7:0], b2[7:0], b1[7:0], b0[7:0]};
   endfunction

   task automatic model(input bit m64, input logic [63:0] w, input logic [63:0] s);
      int b[NBY];
      int p = 0;
      bit lk = 0, o16 = 0, rw = 0, rr = 0;
      int width;
      for (int i = 0; i < NBY; i++) b[i] = int'(w[8*i +: 8]);
      while (p < NPF && (b[p] == 'h66 || b[p] == 'hF0)) begin
         if (b[p] == 'h66) o16 = 1; else lk = 1;
         p++;
      end
      if (m64 && (b[p] / 16) == 4) begin
         rw = b[p][3];
         rr = b[p][2];
         p++;
      end
      e_valid = 1;
      e_hit = (b[p] == 'h0F) && (b[p+1] == 'hBD);
      e_size = rw ? 2 : (o16 ? 0 : 1);
      width  = rw ? 64 : (o16 ? 16 : 32);
      e_reg = (rr ? 8 : 0) + ((b[p+2] / 8) % 8);
      e_idx = -1;
      for (int i = 0; i < width; i++) if (s[i]) e_idx = i;
      e_nb = !e_hit;
      e_ud = e_hit && lk;
      e_we = e_hit && !lk && (e_idx >= 0);
      e_zf = e_hit && !lk && (e_idx < 0);
   endtask

   task automatic fail_line(input string req, input string fld, input int act, input int exp);
      $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, e_tag, fld, act, exp);
   endtask

   task automatic compare();
      bit bad = 0;
      if (!have_exp) return;
      vectors++;
      if (out_valid !== e_valid) begin bad = 1; fail_line("R9", "out_valid", out_valid, e_valid); end
      if (not_bsr !== e_nb) begin bad = 1; fail_line("R1", "not_bsr", not_bsr, e_nb); end
      if (ud_fault !== e_ud) begin bad = 1; fail_line("R5", "ud_fault", ud_fault, e_ud); end
      if (wr_en !== e_we) begin bad = 1; fail_line("R6", "wr_en", wr_en, e_we); end
      if (zf !== e_zf) begin bad = 1; fail_line("R7", "zf", zf, e_zf); end
      if (other_flags !== 5'b0) begin bad = 1; fail_line("R8", "other_flags", other_flags, 0); end
      if (!e_valid && !rst_n) begin
         if (wr_reg !== 4'd0 || op_size !== 2'd0 || result !== 6'd0) begin
            bad = 1; fail_line("R9", "reset data", {wr_reg, op_size, result}, 0);
         end
      end
      if (e_valid && e_hit) begin
         if (op_size !== 2'(e_size)) begin bad = 1; fail_line("R2", "op_size", op_size, e_size); end
         if (wr_reg !== 4'(e_reg)) begin bad = 1; fail_line("R4", "wr_reg", wr_reg, e_reg); end
      end
      if (e_we && result !== 6'(e_idx)) begin bad = 1; fail_line("R6", "result", result, e_idx); end
      if (bad) miscompares++;
   endtask

   task automatic drive(input string tag, input bit m64, input logic [63:0] w, input logic [63:0] s);
      @(negedge clk);
      compare();
      in_valid = 1; mode_64 = m64; insn_bytes = w; src_data = s;
      model(m64, w, s);
      e_tag = tag;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
         in_valid = 0;
         insn_bytes = pk('hFF, 'hFF, 'hFF, 'hFF, 'hFF, 'hFF, 'hFF, 'hFF);
         e_valid = 0; e_hit = 0; e_nb = 0; e_ud = 0; e_we = 0; e_zf = 0;
         e_tag = "R9 idle";
      end
   endtask

   initial begin
      e_valid = 0; e_hit = 0; e_nb = 0; e_ud = 0; e_we = 0; e_zf = 0;
      // R9: outputs low during reset
      repeat (3) begin @(negedge clk); compare(); end
      rst_n = 1;
      idle(1);
      // R6 basic 32-bit forms
      drive("R6 top bit 32", 0, pk('h0F, 'hBD, 'hC1, 0, 0, 0, 0, 0), 64'h0000_0000_8000_0000);
      drive("R6 bit0 with high junk", 0, pk('h0F, 'hBD, 'hD8, 0, 0, 0, 0, 0), 64'hFFFF_0000_0000_0001);
      drive("R6 mid", 1, pk('h0F, 'hBD, 'h00, 0, 0, 0, 0, 0), 64'h0000_0000_0012_3400);
      // R7 zero after truncation
      drive("R7 only above 32", 1, pk('h0F, 'hBD, 'hC8, 0, 0, 0, 0, 0), 64'h8000_0000_0000_0000);
      drive("R7 only above 16", 0, pk('h66, 'h0F, 'hBD, 'hC0, 0, 0, 0, 0), 64'h0000_0000_0001_0000);
      drive("R7 all zero 64", 1, pk('h48, 'h0F, 'hBD, 'hC0, 0, 0, 0, 0), 64'h0);
      // R2 sizes and priority
      drive("R2 16-bit top", 0, pk('h66, 'h0F, 'hBD, 'hF0, 0, 0, 0, 0), 64'h0000_0000_0000_8000);
      drive("R2 64-bit top", 1, pk('h48, 'h0F, 'hBD, 'hC0, 0, 0, 0, 0), 64'h8000_0000_0000_0000);
      drive("R2 W beats 0x66", 1, pk('h66, 'h48, 'h0F, 'hBD, 'hC0, 0, 0, 0), 64'h0000_0040_0000_0000);
      drive("R2 four prefixes then REX", 1, pk('h66, 'hF0, 'h66, 'h66, 'h4C, 'h0F, 'hBD, 'hC0), 64'h1);
      drive("R2 four prefixes no lock", 1, pk('h66, 'h66, 'h66, 'h66, 'h4C, 'h0F, 'hBD, 'hF8), 64'h0000_1000_0000_0000);
      drive("R2 window overrun", 1, pk('h66, 'h66, 'h66, 'h66, 'h66, 'h0F, 'hBD, 'hC0), 64'h1);
      // R4 register extension
      drive("R4 REX.R reg 15", 1, pk('h44, 'h0F, 'hBD, 'hF8, 0, 0, 0, 0), 64'h0000_0000_0000_0100);
      drive("R4 no REX reg 5", 1, pk('h0F, 'hBD, 'h28, 0, 0, 0, 0, 0), 64'h3);
      // R3 REX placement and mode
      drive("R3 REX in legacy mode", 0, pk('h48, 'h0F, 'hBD, 'hC0, 0, 0, 0, 0), 64'h1);
      drive("R3 REX before 0x66", 1, pk('h48, 'h66, 'h0F, 'hBD, 'hC0, 0, 0, 0), 64'h1);
      // R5 lock
      drive("R5 lock", 1, pk('hF0, 'h0F, 'hBD, 'hC0, 0, 0, 0, 0), 64'hFFFF_FFFF_FFFF_FFFF);
      drive("R5 lock with zero", 0, pk('h66, 'hF0, 'h0F, 'hBD, 'hC0, 0, 0, 0), 64'h0);
      // R1 wrong opcodes
      drive("R1 forward-scan opcode", 1, pk('h0F, 'hBC, 'hC0, 0, 0, 0, 0, 0), 64'h1);
      drive("R1 no escape", 0, pk('hBD, 'h0F, 'hC0, 0, 0, 0, 0, 0), 64'h1);
      idle(2);
      drive("R9 after gap", 1, pk('h0F, 'hBD, 'hC0, 0, 0, 0, 0, 0), 64'h0000_0000_0000_0002);
      idle(1);
      // random mix, both modes
      for (int n = 0; n < 600; n++) begin
         int menu[8] = '{'h66, 'hF0, 'h48, 'h44, 'h4C, 'h40, 'h0F, 'h90};
         int bb[NBY];
         int np = int'($urandom_range(0, 5));
         logic [63:0] s;
         for (int i = 0; i < NBY; i++) bb[i] = int'($urandom_range(0, 255));
         for (int i = 0; i < np && i < NBY - 3; i++) bb[i] = menu[$urandom_range(0, 7)];
         if (np <= NBY - 2) begin
            bb[np] = ($urandom_range(0, 9) == 0) ? 'hBC : 'h0F;
            bb[np + 1] = 'hBD;
         end
         case ($urandom_range(0, 3))
            0: s = 64'h0;
            1: s = 64'h1 << $urandom_range(0, 63);
            2: s = {$urandom(), $urandom()} >> $urandom_range(0, 63);
            default: s = {$urandom(), $urandom()};
         endcase
         drive("random", 1'($urandom_range(0, 1)),
               pk(bb[0], bb[1], bb[2], bb[3], bb[4], bb[5], bb[6], bb[7]), s);
         if ($urandom_range(0, 7) == 0) idle(1);
      end
      idle(2);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      #(20ns * 200000);
      if (!finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL R9 watchdog actual=%0d expected=%0d", vectors, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule